// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a small in-order processor core that runs a 32-bit subset of a classic load/store instruction set: word load, word store, add, subtract, bitwise and, bitwise or, and branch-if-equal. Every instruction passes through five stages: fetch, decode with register read, execute, memory access and writeback. Once the pipe is full, one instruction retires per clock. Instruction memory and data memory are separate internal arrays, so a fetch and a data access can happen in the same cycle.

A decoder in the decode stage produces the control bits. They are split into three groups by the stage that consumes them, and each group travels in the pipeline registers with its instruction until that stage has used it. The core has no hazard detection, no forwarding, no stalls and no squashing. Software must place independent instructions or no-ops so that no value is read before it is written. The one exception is that the register file returns a value written in the same cycle.

While reset is held, a loader port fills the instruction memory, the data memory and the register file. A debug read port and the writeback bus let the surrounding logic watch the results.

Top module: `pipe5_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC returns to 0 and all four stage registers clear to zero, so that each acts as a no-op. After release, `wb_we_o` stays low for the first three edges.
- R2: The PC and the stage registers load on every rising edge and have no enable. Without a redirect, `pc_o` grows by 4 on each edge after reset.
- R3: An instruction fetched at edge k appears on the writeback bus (`wb_we_o`, `wb_idx_o`, `wb_val_o`) after edge k+4. Consecutive instructions retire on consecutive cycles.
- R4: The encoding is: opcode in bits [31:26] (0x00 register form, 0x23 load, 0x2B store, 0x04 branch-equal); source registers in [25:21] and [20:16]; destination in [15:11]; 16-bit immediate in [15:0]; function code in [5:0] (0x20 add, 0x22 sub, 0x24 and, 0x25 or). Any other opcode, and any register-form word with another function code (including the all-zero word), changes no register and no memory word.
- R5: Register-form instructions write rs+rt, rs−rt, rs&rt or rs|rt, in 32-bit wrap-around arithmetic, to the register named in bits [15:11].
- R6: Loads and stores use the address rs plus the sign-extended immediate. The data word index is address bits [7:2]. A load writes the data word to the register named in bits [20:16]. A store writes rt to memory and writes no register.
- R7: A register written in the writeback stage reads back with its new value in the decode stage of the same cycle.
- R8: Register 0 always reads as zero, and writes to it are discarded.
- R9: When rs equals rt, a branch loads the PC with (its address + 4) + (sign-extended immediate × 4) on the edge that ends its memory-stage cycle. The three instructions after the branch still complete, and the instruction four words after it is never executed. A branch whose operands differ leaves sequential fetch unchanged.
- R10: While `rst` is high, the loader writes `ld_data` at index `ld_addr` into the instruction memory, data memory or register file, as selected by its strobe. The loaded values are visible through `dbg_val` and are used by the program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_imem_we | input | 1 | Loader strobe for instruction memory |
| ld_dmem_we | input | 1 | Loader strobe for data memory |
| ld_reg_we | input | 1 | Loader strobe for the register file |
| ld_addr | input | LD_AW | Loader word index or register number |
| ld_data | input | 32 | Loader write data |
| dbg_idx | input | 5 | Debug register number |
| dbg_val | output | 32 | Debug register value |
| pc_o | output | 32 | Current fetch address |
| wb_we_o | output | 1 | Writeback stage writes a register |
| wb_idx_o | output | 5 | Writeback destination register |
| wb_val_o | output | 32 | Writeback value |

## Verification
The assertions take for granted that the loader strobes are used only while reset is high. They also assume the running program has no read-after-write dependency closer than three instructions, and that at most one loader strobe is active at a time. The bench loads all memories and registers under reset before it releases it. Its program spaces each dependent pair three or more instructions apart, and one pair sits at exactly three so that the same-cycle register-file path is used. It fills the three slots after each branch with independent instructions or no-ops.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

    localparam int XLEN  = 32;
    localparam int RIDXW = 5;

    localparam logic [5:0] OPC_REG   = 6'h00;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'd0,
        AOP_SUB   = 2'd1,
        AOP_FUNCT = 2'd2
    } aluop_e;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_AND = 2'd2,
        ALU_OR  = 2'd3
    } alufn_e;

    typedef struct packed {
        logic   alu_imm;
        aluop_e alu_op;
        logic   dst_rd;
    } ex_ctl_t;

    typedef struct packed {
        logic rd_en;
        logic wr_en;
        logic branch;
    } mem_ctl_t;

    typedef struct packed {
        logic reg_wr;
        logic from_mem;
    } wb_ctl_t;

    typedef struct packed {
        logic [XLEN-1:0] pc4;
        logic [XLEN-1:0] instr;
    } ifid_t;

    typedef struct packed {
        ex_ctl_t          ex;
        mem_ctl_t         mem;
        wb_ctl_t          wb;
        logic [XLEN-1:0]  pc4;
        logic [XLEN-1:0]  rs_val;
        logic [XLEN-1:0]  rt_val;
        logic [XLEN-1:0]  imm;
        logic [RIDXW-1:0] rt_idx;
        logic [RIDXW-1:0] rd_idx;
    } idex_t;

    typedef struct packed {
        mem_ctl_t         mem;
        wb_ctl_t          wb;
        logic [XLEN-1:0]  target;
        logic             zero;
        logic [XLEN-1:0]  alu_res;
        logic [XLEN-1:0]  store_val;
        logic [RIDXW-1:0] dst;
    } exmem_t;

    typedef struct packed {
        wb_ctl_t          wb;
        logic [XLEN-1:0]  load_val;
        logic [XLEN-1:0]  alu_res;
        logic [RIDXW-1:0] dst;
    } memwb_t;

endpackage

// File: rtl/p5_decoder.sv
module p5_decoder
    import pipe5_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ex_ctl_t         ex_ctl,
    output mem_ctl_t        mem_ctl,
    output wb_ctl_t         wb_ctl
);

    logic [5:0] opc;
    logic [5:0] fn;
    logic       fn_known;

    assign opc = instr[31:26];
    assign fn  = instr[5:0];

    always_comb begin
        fn_known = 1'b0;
        unique case (fn)
            FN_ADD, FN_SUB, FN_AND, FN_OR: fn_known = 1'b1;
            default:                       fn_known = 1'b0;
        endcase
    end

    always_comb begin
        ex_ctl  = '0;
        mem_ctl = '0;
        wb_ctl  = '0;
        unique case (opc)
            OPC_REG: begin
                if (fn_known) begin
                    ex_ctl.alu_op = AOP_FUNCT;
                    ex_ctl.dst_rd = 1'b1;
                    wb_ctl.reg_wr = 1'b1;
                end
            end
            OPC_LOAD: begin
                ex_ctl.alu_imm  = 1'b1;
                ex_ctl.alu_op   = AOP_ADD;
                mem_ctl.rd_en   = 1'b1;
                wb_ctl.reg_wr   = 1'b1;
                wb_ctl.from_mem = 1'b1;
            end
            OPC_STORE: begin
                ex_ctl.alu_imm = 1'b1;
                ex_ctl.alu_op  = AOP_ADD;
                mem_ctl.wr_en  = 1'b1;
            end
            OPC_BEQ: begin
                ex_ctl.alu_op  = AOP_SUB;
                mem_ctl.branch = 1'b1;
            end
            default: begin
                ex_ctl  = '0;
                mem_ctl = '0;
                wb_ctl  = '0;
            end
        endcase
    end

endmodule

// File: rtl/p5_alu.sv
module p5_alu
    import pipe5_pkg::*;
(
    input  aluop_e          op,
    input  logic [5:0]      funct,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y,
    output logic            zero
);

    alufn_e fn;

    always_comb begin
        fn = ALU_ADD;
        unique case (op)
            AOP_ADD: fn = ALU_ADD;
            AOP_SUB: fn = ALU_SUB;
            AOP_FUNCT: begin
                unique case (funct)
                    FN_SUB:  fn = ALU_SUB;
                    FN_AND:  fn = ALU_AND;
                    FN_OR:   fn = ALU_OR;
                    default: fn = ALU_ADD;
                endcase
            end
            default: fn = ALU_ADD;
        endcase
    end

    always_comb begin
        unique case (fn)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/p5_regfile.sv
module p5_regfile #(
    parameter int NREG = 32,
    parameter int DW   = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic [AW-1:0] ra_idx,
    output logic [DW-1:0] ra_val,
    input  logic [AW-1:0] rb_idx,
    output logic [DW-1:0] rb_val,
    input  logic [AW-1:0] rc_idx,
    output logic [DW-1:0] rc_val,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_val
);

    logic [DW-1:0] cells [NREG];

    // write-first read: a same-cycle write is returned to the reader
    function automatic logic [DW-1:0] read_port(input logic [AW-1:0] idx);
        if (idx == '0)
            return '0;
        else if (wr_en && (wr_idx == idx))
            return wr_val;
        else
            return cells[idx];
    endfunction

    always_comb begin
        ra_val = read_port(ra_idx);
        rb_val = read_port(rb_idx);
        rc_val = read_port(rc_idx);
    end

    always_ff @(posedge clk) begin
        if (wr_en && (wr_idx != '0))
            cells[wr_idx] <= wr_val;
    end

    AST_ZERO_REG_READ: assert property (@(posedge clk) (ra_idx == '0) |-> (ra_val == '0)); // R8
    AST_WRITE_LANDS: assert property (@(posedge clk)
        (wr_en && (wr_idx != '0)) |=> (cells[$past(wr_idx)] == $past(wr_val))); // R7

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    parameter int LD_AW      = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_imem_we,
    input  logic             ld_dmem_we,
    input  logic             ld_reg_we,
    input  logic [LD_AW-1:0] ld_addr,
    input  logic [XLEN-1:0]  ld_data,
    input  logic [RIDXW-1:0] dbg_idx,
    output logic [XLEN-1:0]  dbg_val,
    output logic [XLEN-1:0]  pc_o,
    output logic             wb_we_o,
    output logic [RIDXW-1:0] wb_idx_o,
    output logic [XLEN-1:0]  wb_val_o
);

    localparam int IA_W = $clog2(IMEM_WORDS);
    localparam int DA_W = $clog2(DMEM_WORDS);

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0] pc_q, pc_d, pc4;
    ifid_t  ifid_q,  ifid_d;
    idex_t  idex_q,  idex_d;
    exmem_t exmem_q, exmem_d;
    memwb_t memwb_q, memwb_d;
    logic   pc_src;

    // ---------------- fetch ----------------
    assign pc4  = pc_q + 32'd4;
    assign pc_d = pc_src ? exmem_q.target : pc4;

    always_comb begin
        ifid_d.pc4   = pc4;
        ifid_d.instr = imem[pc_q[IA_W+1:2]];
    end

    always_ff @(posedge clk) begin
        if (ld_imem_we)
            imem[ld_addr[IA_W-1:0]] <= ld_data;
    end

    // ---------------- decode ----------------
    ex_ctl_t  dec_ex;
    mem_ctl_t dec_mem;
    wb_ctl_t  dec_wb;
    logic [XLEN-1:0]  rs_val, rt_val, rf_wval;
    logic [RIDXW-1:0] rf_widx;
    logic             rf_we;

    p5_decoder u_dec (
        .instr   (ifid_q.instr),
        .ex_ctl  (dec_ex),
        .mem_ctl (dec_mem),
        .wb_ctl  (dec_wb)
    );

    // loader has priority on the single write port
    always_comb begin
        if (ld_reg_we) begin
            rf_we   = 1'b1;
            rf_widx = ld_addr[RIDXW-1:0];
            rf_wval = ld_data;
        end else begin
            rf_we   = memwb_q.wb.reg_wr;
            rf_widx = memwb_q.dst;
            rf_wval = memwb_q.wb.from_mem ? memwb_q.load_val : memwb_q.alu_res;
        end
    end

    p5_regfile #(.NREG(32), .DW(XLEN)) u_rf (
        .clk    (clk),
        .ra_idx (ifid_q.instr[25:21]),
        .ra_val (rs_val),
        .rb_idx (ifid_q.instr[20:16]),
        .rb_val (rt_val),
        .rc_idx (dbg_idx),
        .rc_val (dbg_val),
        .wr_en  (rf_we),
        .wr_idx (rf_widx),
        .wr_val (rf_wval)
    );

    always_comb begin
        idex_d.ex     = dec_ex;
        idex_d.mem    = dec_mem;
        idex_d.wb     = dec_wb;
        idex_d.pc4    = ifid_q.pc4;
        idex_d.rs_val = rs_val;
        idex_d.rt_val = rt_val;
        idex_d.imm    = {{(XLEN-16){ifid_q.instr[15]}}, ifid_q.instr[15:0]};
        idex_d.rt_idx = ifid_q.instr[20:16];
        idex_d.rd_idx = ifid_q.instr[15:11];
    end

    // ---------------- execute ----------------
    logic [XLEN-1:0] alu_b, alu_y;
    logic            alu_zero;

    assign alu_b = idex_q.ex.alu_imm ? idex_q.imm : idex_q.rt_val;

    p5_alu u_alu (
        .op    (idex_q.ex.alu_op),
        .funct (idex_q.imm[5:0]),
        .a     (idex_q.rs_val),
        .b     (alu_b),
        .y     (alu_y),
        .zero  (alu_zero)
    );

    always_comb begin
        exmem_d.mem       = idex_q.mem;
        exmem_d.wb        = idex_q.wb;
        exmem_d.target    = idex_q.pc4 + {idex_q.imm[XLEN-3:0], 2'b00};
        exmem_d.zero      = alu_zero;
        exmem_d.alu_res   = alu_y;
        exmem_d.store_val = idex_q.rt_val;
        exmem_d.dst       = idex_q.ex.dst_rd ? idex_q.rd_idx : idex_q.rt_idx;
    end

    // ---------------- memory ----------------
    logic [DA_W-1:0] dm_idx;
    assign dm_idx = exmem_q.alu_res[DA_W+1:2];
    assign pc_src = exmem_q.mem.branch & exmem_q.zero;

    always_ff @(posedge clk) begin
        if (ld_dmem_we)
            dmem[ld_addr[DA_W-1:0]] <= ld_data;
        else if (exmem_q.mem.wr_en)
            dmem[dm_idx] <= exmem_q.store_val;
    end

    always_comb begin
        memwb_d.wb       = exmem_q.wb;
        memwb_d.load_val = exmem_q.mem.rd_en ? dmem[dm_idx] : '0;
        memwb_d.alu_res  = exmem_q.alu_res;
        memwb_d.dst      = exmem_q.dst;
    end

    // ---------------- stage registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            ifid_q  <= '0;
            idex_q  <= '0;
            exmem_q <= '0;
            memwb_q <= '0;
        end else begin
            pc_q    <= pc_d;
            ifid_q  <= ifid_d;
            idex_q  <= idex_d;
            exmem_q <= exmem_d;
            memwb_q <= memwb_d;
        end
    end

    // ---------------- writeback view ----------------
    assign pc_o     = pc_q;
    assign wb_we_o  = memwb_q.wb.reg_wr;
    assign wb_idx_o = memwb_q.dst;
    assign wb_val_o = memwb_q.wb.from_mem ? memwb_q.load_val : memwb_q.alu_res;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (pc_q == '0) && (memwb_q == '0) && (exmem_q == '0)); // R1
    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        !pc_src |=> (pc_q == $past(pc_q) + 32'd4)); // R2
    AST_BRANCH_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        pc_src |=> (pc_q == $past(exmem_q.target))); // R9
    AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
        exmem_q.mem.wr_en |=> !memwb_q.wb.reg_wr); // R6
    AST_LOAD_SOURCE: assert property (@(posedge clk) disable iff (rst)
        memwb_q.wb.from_mem |-> $past(exmem_q.mem.rd_en)); // R6

endmodule

// File: tb/pipe5_core_tb.sv
module pipe5_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_imem_we = 1'b0, ld_dmem_we = 1'b0, ld_reg_we = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [4:0]  dbg_idx = '0;
    logic [31:0] dbg_val, pc_o, wb_val_o;
    logic        wb_we_o;
    logic [4:0]  wb_idx_o;

    always #10 clk = ~clk;

    pipe5_core u_dut (
        .clk(clk), .rst(rst),
        .ld_imem_we(ld_imem_we), .ld_dmem_we(ld_dmem_we), .ld_reg_we(ld_reg_we),
        .ld_addr(ld_addr), .ld_data(ld_data),
        .dbg_idx(dbg_idx), .dbg_val(dbg_val),
        .pc_o(pc_o), .wb_we_o(wb_we_o), .wb_idx_o(wb_idx_o), .wb_val_o(wb_val_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int edge_n   = 0;
    bit done     = 1'b0;

    typedef struct {
        int          idx;
        logic [31:0] val;
        int          at_edge;
    } wb_item_t;
    wb_item_t sb_q[$];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_wb(input int idx, input logic [31:0] val, input int at_edge);
        wb_item_t it;
        it.idx = idx; it.val = val; it.at_edge = at_edge;
        sb_q.push_back(it);
    endtask

    function automatic logic [31:0] rform(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    function automatic logic [31:0] iform(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, rs[4:0], rt[4:0], imm};
    endfunction

    task automatic load(input int sel, input int addr, input logic [31:0] data);
        @(negedge clk);
        ld_imem_we = (sel == 0);
        ld_dmem_we = (sel == 1);
        ld_reg_we  = (sel == 2);
        ld_addr    = addr[5:0];
        ld_data    = data;
        @(negedge clk);
        ld_imem_we = 1'b0; ld_dmem_we = 1'b0; ld_reg_we = 1'b0;
    endtask

    always @(posedge clk) begin
        if (rst) edge_n = 0;
        else     edge_n = edge_n + 1;
    end

    // monitor: PC trace and writeback scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [31:0] exp_pc;
            exp_pc = (edge_n < 13) ? 32'(4 * edge_n) : 32'(56 + 4 * (edge_n - 13));
            if (edge_n <= 30)
                check(pc_o == exp_pc, "R2/R9 pc trace", pc_o, exp_pc);
            if (edge_n <= 3)
                check(!wb_we_o, "R1 bubble after reset", 32'(wb_we_o), 32'd0);
            if (wb_we_o && wb_idx_o != 5'd0) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R4/R9 unexpected writeback", 32'(wb_idx_o), 32'd0);
                end else begin
                    wb_item_t it;
                    it = sb_q.pop_front();
                    check(32'(wb_idx_o) == it.idx, "R3 writeback register", 32'(wb_idx_o), it.idx);
                    check(wb_val_o == it.val, "R5/R6 writeback value", wb_val_o, it.val);
                    check(edge_n == it.at_edge, "R3 writeback cycle", edge_n, it.at_edge);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] prog [20];
        // R10 preload registers (index+100) and data words (99)
        for (int i = 0; i < 32; i++) load(2, i, 32'(i + 100));
        for (int i = 0; i < 64; i++) load(1, i, 32'd99);
        for (int i = 0; i < 20; i++) prog[i] = 32'h0;
        prog[0]  = iform(6'h23, 29, 8, 16'd4);          // lw r8,4(r29)
        prog[1]  = rform(4, 5, 2, 6'h22);               // sub r2
        prog[2]  = rform(10, 11, 9, 6'h24);             // and r9
        prog[3]  = rform(17, 18, 16, 6'h25);            // or r16
        prog[4]  = rform(14, 0, 13, 6'h20);             // add r13
        prog[5]  = rform(9, 8, 21, 6'h20);              // add r21 (same-cycle read of r9)
        prog[6]  = iform(6'h2B, 0, 2, 16'd8);           // sw r2,8(r0)
        prog[7]  = iform(6'h23, 0, 22, 16'd8);          // lw r22,8(r0)
        prog[8]  = rform(4, 5, 0, 6'h20);               // add r0 (discarded)
        prog[9]  = iform(6'h04, 1, 1, 16'd4);           // beq taken -> 56
        prog[10] = iform(6'h08, 1, 26, 16'd5);          // unknown opcode
        prog[13] = rform(1, 1, 23, 6'h20);              // skipped
        prog[14] = rform(3, 0, 24, 6'h25);              // or r24
        prog[15] = iform(6'h04, 1, 2, 16'd5);           // beq not taken
        prog[19] = rform(6, 7, 25, 6'h20);              // add r25
        for (int i = 0; i < 20; i++) load(0, i, prog[i]);
        for (int i = 20; i < 64; i++) load(0, i, 32'h0);

        @(negedge clk);
        check(pc_o == 32'd0, "R1 reset pc", pc_o, 32'd0);
        check(!wb_we_o, "R1 reset writeback", 32'(wb_we_o), 32'd0);
        dbg_idx = 5'd5; #1;
        check(dbg_val == 32'd105, "R10 preload visible", dbg_val, 32'd105);
        dbg_idx = 5'd0; #1;
        check(dbg_val == 32'd0, "R8 r0 load discarded", dbg_val, 32'd0);

        expect_wb(8,  32'd99,        4);   // R6 load
        expect_wb(2,  32'hFFFF_FFFF, 5);   // R5 sub wraps
        expect_wb(9,  32'd110,       6);   // R5 and
        expect_wb(16, 32'd119,       7);   // R5 or
        expect_wb(13, 32'd114,       8);   // R5 add
        expect_wb(21, 32'd209,       9);   // R7 same-cycle read
        expect_wb(22, 32'hFFFF_FFFF, 11);  // R6 store then load
        expect_wb(24, 32'd103,       17);  // R9 branch target
        expect_wb(25, 32'd213,       22);  // R9 not-taken path

        @(negedge clk);
        rst = 1'b0;
        repeat (36) @(negedge clk);

        check(sb_q.size() == 0, "R3 all writebacks seen", sb_q.size(), 0);
        dbg_idx = 5'd0;  #1; check(dbg_val == 32'd0,   "R8 r0 stays zero", dbg_val, 32'd0);
        dbg_idx = 5'd23; #1; check(dbg_val == 32'd123, "R9 skipped word", dbg_val, 32'd123);
        dbg_idx = 5'd26; #1; check(dbg_val == 32'd126, "R4 unknown opcode", dbg_val, 32'd126);
        dbg_idx = 5'd8;  #1; check(dbg_val == 32'd99,  "R6 loaded value", dbg_val, 32'd99);
        dbg_idx = 5'd21; #1; check(dbg_val == 32'd209, "R7 bypassed operand", dbg_val, 32'd209);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule